// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Streamer

This block sits beside the two-wire serial front end of a secure memory. When the host raises and then lowers the reset line while the device is selected and no nonvolatile write is busy, it streams a fixed 32-bit identification value. The value goes out one bit per serial clock, in byte 0 first, least significant bit first order. The pattern repeats for as long as the host keeps clocking. The serial data line is open drain, so the block only asserts a pull-low enable, and only for a 0 bit.

All inputs are assumed to be already synchronized to the block's system clock. The block finds edges by comparing each input with its value one cycle earlier. While a stream is armed, running or halted, it raises a hold flag that keeps the normal command front end idle. Deselection aborts everything at once. A second reset pulse during the stream halts it with the line released, and the halt is left only through a stop condition on the bus or through deselection.

Top module: `atr_streamer`

## Requirements
- R1: A rising edge on `rst_pin` seen while `cs_n` is 0 and `wr_busy` is 0 arms the streamer: `fe_hold` is 1 from the next cycle on. A new arming always restarts at pattern bit 0.
- R2: While armed and `rst_pin` is still high, `sda_oe` is 0. The first stream bit appears the cycle after `rst_pin` falls, with no serial clock needed.
- R3: Stream bit k (k = 0..31) is bit `8*(3 - k/8) + k%8` of `PATTERN` (default 32'h1901AA55), so bytes go out 0x19, 0x01, 0xAA, 0x55 and each byte goes out LSB first. `sda_oe` = 1 drives a 0 bit and `sda_oe` = 0 releases the line for a 1 bit.
- R4: Each falling edge of `scl` while streaming advances to the next bit, visible in the cycle after the edge is sampled. `sda_oe` does not change between falling edges.
- R5: After bit 31 the next falling edge of `scl` returns to bit 0, and the pattern repeats without end.
- R6: `cs_n` = 1 in any state returns the block to standby in the next cycle, with `sda_oe` = 0 and `fe_hold` = 0. Later clocks and reset edges have no effect until arming happens again.
- R7: A reset pulse while `wr_busy` = 1, or while `cs_n` = 1, does not arm: `fe_hold` and `sda_oe` stay 0.
- R8: A rising edge on `rst_pin` while streaming halts the stream: `sda_oe` is 0 and `fe_hold` stays 1. In this state `scl` edges are ignored until a stop condition occurs (`sda_in` rises while `scl` is high), which returns the block to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| cs_n | input | 1 | Device select, low = selected |
| rst_pin | input | 1 | Host reset line that requests the answer-to-reset stream |
| scl | input | 1 | Serial clock level, already synchronized |
| sda_in | input | 1 | Serial data line level, used for stop detection |
| wr_busy | input | 1 | High while a nonvolatile write cycle is running |
| sda_oe | output | 1 | Pull-low enable for the open-drain data line |
| fe_hold | output | 1 | Holds the command front end idle while the streamer owns the bus |

## Verification
The hardest condition to reach is the halted state after the pattern has wrapped. It needs a full arming sequence, more than 32 serial clock falls, a second reset pulse and then a stop condition whose data edge lands while the clock is high. The bench walks the stream for 70 bits, comparing every bit against a value computed from the pattern parameter. It then halts the stream with a second reset pulse, clocks through the halt to show it is quiet, and ends the halt with an explicit stop condition. Aborts through deselection and arming attempts that must be refused are placed both mid-stream and during the armed phase.

// File: rtl/atr_streamer.sv
module atr_streamer #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] PATTERN = 32'h1901AA55
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rst_pin,
  input  logic scl,
  input  logic sda_in,
  input  logic wr_busy,
  output logic sda_oe,
  output logic fe_hold
);
  localparam int PW = $clog2(WIDTH);
  localparam int NBYTES = WIDTH / 8;
  localparam logic [PW-1:0] LAST = PW'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_STREAM, S_HALT} st_t;

  st_t st;
  logic [PW-1:0] ptr, idx;
  logic rst_q, scl_q, sda_q;

  wire rst_rise  = rst_pin & ~rst_q;
  wire rst_fall  = ~rst_pin & rst_q;
  wire scl_fall  = ~scl & scl_q;
  wire stop_seen = scl & scl_q & sda_in & ~sda_q;

  always_comb idx = PW'((NBYTES - 1 - int'(ptr) / 8) * 8 + int'(ptr) % 8);

  assign sda_oe  = (st == S_STREAM) & ~PATTERN[idx];
  assign fe_hold = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr   <= '0;
      rst_q <= 1'b0;
      scl_q <= 1'b0;
      sda_q <= 1'b1;
    end else begin
      rst_q <= rst_pin;
      scl_q <= scl;
      sda_q <= sda_in;
      if (cs_n) st <= S_IDLE;
      else begin
        case (st)
          S_IDLE:   if (rst_rise && !wr_busy) begin st <= S_ARMED; ptr <= '0; end
          S_ARMED:  if (rst_fall) st <= S_STREAM;
          S_STREAM: if (rst_rise) st <= S_HALT;
                    else if (scl_fall) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
          S_HALT:   if (stop_seen) st <= S_IDLE;
          default:  st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module atr_streamer_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rst_pin,
  input logic scl,
  input logic wr_busy,
  input logic sda_oe,
  input logic fe_hold,
  input logic [1:0] st
);
  a_r6_deselect_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!fe_hold && !sda_oe));
  a_r7_busy_blocks_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_hold && wr_busy) |=> !fe_hold);
  a_r2_released_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> !sda_oe);
  a_r8_halt_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |-> (!sda_oe && fe_hold));
  a_r4_stable_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !$fell(scl) && !$rose(rst_pin) && !cs_n) |=> $stable(sda_oe));
endmodule

bind atr_streamer atr_streamer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rst_pin(rst_pin), .scl(scl),
  .wr_busy(wr_busy), .sda_oe(sda_oe), .fe_hold(fe_hold), .st(st)
);

// File: tb/atr_streamer_test.sv
module atr_streamer_test;
  localparam logic [31:0] PAT = 32'h1901AA55;
  logic clk = 0, rst_n = 0, cs_n = 1, rst_pin = 0, scl = 0, sda_in = 1, wr_busy = 0;
  logic sda_oe, fe_hold;
  int checks = 0, fails = 0;
  bit done = 0;

  atr_streamer uut (.*);

  always #5 clk = ~clk;

  function automatic logic exp_bit(int k);
    int kk = k % 32;
    return PAT[(3 - kk / 8) * 8 + kk % 8];
  endfunction

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic act_oe, logic exp_oe, logic act_h, logic exp_h);
    checks++;
    if (act_oe !== exp_oe || act_h !== exp_h) begin
      fails++;
      $display("FAIL %s: sda_oe=%b fe_hold=%b expected sda_oe=%b fe_hold=%b",
               req, act_oe, act_h, exp_oe, exp_h);
    end
  endtask

  task automatic scl_pulse();
    scl = 1; cyc(); scl = 0; cyc();
  endtask

  task automatic arm();
    cs_n = 0; cyc();
    rst_pin = 1; cyc();
    chk("R2 armed released", sda_oe, 1'b0, fe_hold, 1'b1);
    rst_pin = 0; cyc();
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc();
    chk("R1 reset state", sda_oe, 1'b0, fe_hold, 1'b0);

    arm();
    chk("R2 first bit without clock", sda_oe, ~exp_bit(0), fe_hold, 1'b1);
    for (int k = 0; k < 70; k++) begin
      chk(k < 32 ? "R3 stream bit" : "R5 wrapped bit", sda_oe, ~exp_bit(k), fe_hold, 1'b1);
      scl = 1; cyc();
      chk("R4 stable while scl high", sda_oe, ~exp_bit(k), fe_hold, 1'b1);
      scl = 0; cyc();
    end

    rst_pin = 1; cyc();
    chk("R8 halt on second pulse", sda_oe, 1'b0, fe_hold, 1'b1);
    rst_pin = 0; cyc();
    for (int i = 0; i < 4; i++) begin
      scl_pulse();
      chk("R8 halted ignores clock", sda_oe, 1'b0, fe_hold, 1'b1);
    end
    scl = 1; cyc(); sda_in = 0; cyc();
    chk("R8 no exit before stop", sda_oe, 1'b0, fe_hold, 1'b1);
    sda_in = 1; cyc();
    chk("R8 stop returns to standby", sda_oe, 1'b0, fe_hold, 1'b0);
    scl = 0; cyc();

    arm();
    for (int k = 0; k < 5; k++) scl_pulse();
    chk("R3 mid-stream bit 5", sda_oe, ~exp_bit(5), fe_hold, 1'b1);
    cs_n = 1; cyc();
    chk("R6 deselect aborts", sda_oe, 1'b0, fe_hold, 1'b0);
    cs_n = 0; cyc();
    for (int i = 0; i < 3; i++) begin
      scl_pulse();
      chk("R6 no effect after abort", sda_oe, 1'b0, fe_hold, 1'b0);
    end

    arm();
    for (int k = 0; k < 8; k++) begin
      chk("R1 rearm restarts at bit 0", sda_oe, ~exp_bit(k), fe_hold, 1'b1);
      scl_pulse();
    end
    cs_n = 1; cyc();

    cs_n = 0; cyc(); rst_pin = 1; cyc();
    cs_n = 1; cyc();
    chk("R6 abort while armed", sda_oe, 1'b0, fe_hold, 1'b0);
    rst_pin = 0; cyc(); cs_n = 0; cyc();
    chk("R6 fall after abort ignored", sda_oe, 1'b0, fe_hold, 1'b0);

    wr_busy = 1; rst_pin = 1; cyc();
    chk("R7 busy blocks arm", sda_oe, 1'b0, fe_hold, 1'b0);
    rst_pin = 0; cyc(); scl_pulse();
    chk("R7 busy stays standby", sda_oe, 1'b0, fe_hold, 1'b0);
    wr_busy = 0; cyc();

    cs_n = 1; rst_pin = 1; cyc(); rst_pin = 0; cyc(); cs_n = 0; cyc();
    chk("R7 deselected pulse ignored", sda_oe, 1'b0, fe_hold, 1'b0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule